// File: doc/BRIEF.md
# Bus-Mapped Character Display Bridge

This block lets a microcontroller with a multiplexed external bus reach a character display controller through ordinary external data-memory reads and writes. The low address byte is caught while the address-latch strobe is high. The high address byte is decoded against a fixed four-location window. Two high address bits directly choose the display's register-select and read/write lines. The display enable pulse is built from the bus read and write strobes. It rises only after a programmable setup interval. After it falls, the control lines are held for a programmable interval.

All timing is counted in cycles of a local clock. The bus strobes pass through a synchronizer whose depth is a parameter. During a read in the window, the bridge turns the display data around onto the processor bus. At every other time it passes processor data through to the display side.

There is no valid/ready interface here. The processor's strobes set the pace of every transfer and cannot be stalled, so the bridge applies no back-pressure. It must finish each transfer inside the strobe's low time.

Top module: `lcd_bus_bridge`

## Requirements
- R1: After reset, `lcd_e` is 0, `ad_oe` is 0, `lcd_db_oe` is 1, and both `lcd_rs` and `lcd_rw` are 0.
- R2: The display is selected only when `a_hi[7:2]` equals `WIN_TAG` (default 6'b101010, addresses 0xA8xx to 0xABxx). A strobe outside the window never raises `lcd_e` or `ad_oe`.
- R3: `lcd_rw` takes `a_hi[0]` (1 = read, 0 = write) and `lcd_rs` takes `a_hi[1]` (1 = data register, 0 = instruction register). So 0xA8 is an instruction write, 0xA9 is a status read, 0xAA is a data write and 0xAB is a data read.
- R4: Number the rising clock edges from 1, starting with the first edge that samples `wr_n` or `rd_n` low. `lcd_e` goes high after edge SYNC_STAGES+SETUP_CYC+1 (6 with the defaults) and not earlier. `lcd_rs` and `lcd_rw` do not change on that edge.
- R5: Number the rising edges from 1, starting with the first edge that samples the strobe high again. `lcd_e` goes low after edge SYNC_STAGES+1 (3 with the defaults).
- R6: `lcd_rs` and `lcd_rw` do not change from the start of a transfer until HOLD_CYC cycles after `lcd_e` falls. With the defaults, an address change is ignored through the 5th edge after the strobe rises and is taken on the 6th.
- R7: During a read transfer in the window, `ad_oe` is 1 and `ad_out` equals `lcd_db_in` while `lcd_e` is high. During the same transfer `lcd_db_oe` is 0.
- R8: `ad_oe` is 0 after the first rising edge that samples `rd_n` high.
- R9: During writes and while idle, `lcd_db_oe` is 1 and `lcd_db_out` equals `ad_in`.
- R10: If the strobe is released early enough that the synchronized strobe goes inactive before the setup interval completes, `lcd_e` never rises. With the defaults, this is a release after the 3rd edge of R4.
- R11: The low byte is captured on every clock edge while `ale` is high. Bits set in `LO_MASK` must also match `LO_VALUE` for the window to hit. For example, with mask 0xFF and value 0xFF, 0xA8FE is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock |
| rst_n | input | 1 | Active-low reset |
| ale | input | 1 | Address latch strobe, high while the low address byte is on the bus |
| wr_n | input | 1 | Active-low bus write strobe |
| rd_n | input | 1 | Active-low bus read strobe |
| ad_in | input | 8 | Multiplexed address/data bus, as received |
| ad_out | output | 8 | Data returned to the processor bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| a_hi | input | 8 | High address byte |
| lcd_db_in | input | 8 | Display data bus, as received |
| lcd_db_out | output | 8 | Data driven toward the display |
| lcd_db_oe | output | 1 | Drive enable for `lcd_db_out` |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write select |
| lcd_e | output | 1 | Display enable strobe |

## Verification
A table of eight bus cycles covers all four window addresses, both strobe types, and four misses. The misses differ in the lower high-address bits, the top bit and the low byte, which shows that every part of the decode matters. Data values differ per vector, so the bench can tell a pass-through from a turnaround. Separate directed cycles then do three things. They release a strobe early, to separate an aborted setup from a started one. They change the address during the hold window, which shows exactly when the control lines may move. They change the idle bus, to confirm the pass-through.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } lcdb_state_t;
endpackage

// File: rtl/lcdb_sync.sv
module lcdb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lcdb_decode.sv
module lcdb_decode #(
  parameter logic [5:0] WIN_TAG  = 6'b101010,
  parameter logic [7:0] LO_MASK  = 8'h00,
  parameter logic [7:0] LO_VALUE = 8'hFF
) (
  input  logic [7:0] hi_addr,
  input  logic [7:0] lo_addr,
  output logic       hit,
  output logic       rs_sel,
  output logic       rw_sel
);
  logic hi_match, lo_match;
  always_comb begin
    hi_match = (hi_addr[7:2] == WIN_TAG);
    lo_match = (((lo_addr ^ LO_VALUE) & LO_MASK) == 8'h00);
    hit      = hi_match && lo_match;
    rw_sel   = hi_addr[0];
    rs_sel   = hi_addr[1];
  end
endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
  import lcdb_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_act,
  input  logic hit,
  input  logic rs_sel,
  input  logic rw_sel,
  input  logic rd_n_raw,
  output logic lcd_e,
  output logic lcd_rs,
  output logic lcd_rw,
  output logic ad_oe,
  output logic lcd_db_oe
);
  localparam int CNT_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CW      = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  lcdb_state_t st;
  logic [CW-1:0] cnt;
  logic rs_q, rw_q, e_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      rs_q <= 1'b0;
      rw_q <= 1'b0;
      e_q  <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= ((st == ST_SETUP) || (st == ST_ACTIVE)) && rw_q && !rd_n_raw;
      case (st)
        ST_IDLE: begin
          if (hit) begin
            rs_q <= rs_sel;
            rw_q <= rw_sel;
            if (strb_act) begin
              st  <= ST_SETUP;
              cnt <= '0;
            end
          end
        end
        ST_SETUP: begin
          if (!strb_act) begin
            st <= ST_IDLE;
          end else if (cnt == SETUP_LAST) begin
            st  <= ST_ACTIVE;
            e_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (!strb_act) begin
            st  <= ST_HOLD;
            e_q <= 1'b0;
            cnt <= '0;
          end
        end
        ST_HOLD: begin
          if (cnt == HOLD_LAST) st <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign lcd_e     = e_q;
  assign lcd_rs    = rs_q;
  assign lcd_rw    = rw_q;
  assign ad_oe     = oe_q;
  assign lcd_db_oe = !(rw_q && (st != ST_IDLE));
endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge #(
  parameter int         SYNC_STAGES = 2,
  parameter int         SETUP_CYC   = 3,
  parameter int         HOLD_CYC    = 2,
  parameter logic [5:0] WIN_TAG     = 6'b101010,
  parameter logic [7:0] LO_MASK     = 8'h00,
  parameter logic [7:0] LO_VALUE    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  input  logic [7:0] a_hi,
  input  logic [7:0] lcd_db_in,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e
);
  logic [7:0] lo_q;
  logic [1:0] strb_s;
  logic hit, rs_sel, rw_sel, strb_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lo_q <= 8'h00;
    else if (ale) lo_q <= ad_in;
  end

  lcdb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({wr_n, rd_n}), .q(strb_s)
  );

  assign strb_act = !(strb_s[1] && strb_s[0]);

  lcdb_decode #(.WIN_TAG(WIN_TAG), .LO_MASK(LO_MASK), .LO_VALUE(LO_VALUE)) u_dec (
    .hi_addr(a_hi), .lo_addr(lo_q), .hit(hit), .rs_sel(rs_sel), .rw_sel(rw_sel)
  );

  lcdb_seq #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .strb_act(strb_act), .hit(hit),
    .rs_sel(rs_sel), .rw_sel(rw_sel), .rd_n_raw(rd_n),
    .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .ad_oe(ad_oe), .lcd_db_oe(lcd_db_oe)
  );

  assign ad_out     = lcd_db_in;
  assign lcd_db_out = ad_in;
endmodule

// File: rtl/lcd_bus_bridge_chk.sv
module lcd_bus_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic lcd_e,
  input logic lcd_rs,
  input logic lcd_rw,
  input logic ad_oe,
  input logic lcd_db_oe
);
  // R7
  read_drive_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> lcd_rw);
  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && lcd_rw) |-> !lcd_db_oe);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> !ad_oe);
  // R4
  setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> ($stable(lcd_rs) && $stable(lcd_rw)));
endmodule

bind lcd_bus_bridge lcd_bus_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .lcd_e(lcd_e), .lcd_rs(lcd_rs),
  .lcd_rw(lcd_rw), .ad_oe(ad_oe), .lcd_db_oe(lcd_db_oe)
);

// File: tb/lcd_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module lcd_bus_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] ad_in = 8'h00, a_hi = 8'h00, lcd_db_in = 8'h00;
  logic [7:0] ad_out, lcd_db_out;
  logic ad_oe, lcd_db_oe, lcd_rs, lcd_rw, lcd_e;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  lcd_bus_bridge #(
    .SYNC_STAGES(2), .SETUP_CYC(3), .HOLD_CYC(2),
    .WIN_TAG(6'b101010), .LO_MASK(8'hFF), .LO_VALUE(8'hFF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ale(ale), .wr_n(wr_n), .rd_n(rd_n),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .lcd_db_in(lcd_db_in), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e)
  );

  localparam int E_RISE = 6;
  localparam int E_FALL = 3;

  typedef struct packed {
    logic [7:0] hi; logic [7:0] lo; logic rd; logic [7:0] wd; logic [7:0] ld;
    logic sel; logic rs; logic rw;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{8'hA8, 8'hFF, 1'b0, 8'h38, 8'h00, 1'b1, 1'b0, 1'b0},
    '{8'hA9, 8'hFF, 1'b1, 8'h00, 8'h80, 1'b1, 1'b0, 1'b1},
    '{8'hAA, 8'hFF, 1'b0, 8'h41, 8'h00, 1'b1, 1'b1, 1'b0},
    '{8'hAB, 8'hFF, 1'b1, 8'h00, 8'h5A, 1'b1, 1'b1, 1'b1},
    '{8'hAC, 8'hFF, 1'b0, 8'h11, 8'h00, 1'b0, 1'b0, 1'b0},
    '{8'hA7, 8'hFF, 1'b1, 8'h00, 8'h22, 1'b0, 1'b0, 1'b0},
    '{8'hA8, 8'hFE, 1'b0, 8'h33, 8'h00, 1'b0, 1'b0, 1'b0},
    '{8'h28, 8'hFF, 1'b0, 8'h44, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo);
    @(negedge clk); ale = 1'b1; ad_in = lo; a_hi = hi;
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic stray;
    stray = 1'b0;
    addr_phase(v.hi, v.lo);
    ad_in = v.wd; lcd_db_in = v.ld;
    if (v.rd) rd_n = 1'b0; else wr_n = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (!v.sel) begin
        if (lcd_e || ad_oe) stray = 1'b1;
      end else if (k == E_RISE - 1) begin
        chk("R4 enable not yet high", lcd_e, 1'b0);
      end else if (k == E_RISE) begin
        chk("R4 enable high", lcd_e, 1'b1);
        chk("R3 rs", lcd_rs, v.rs);
        chk("R3 rw", lcd_rw, v.rw);
        if (v.rd) begin
          chk("R7 cpu drive", ad_oe, 1'b1);
          chk("R7 read data", ad_out, v.ld);
          chk("R7 lcd side released", lcd_db_oe, 1'b0);
        end else begin
          chk("R9 write data", lcd_db_out, v.wd);
          chk("R9 lcd side driven", lcd_db_oe, 1'b1);
        end
      end
    end
    rd_n = 1'b1; wr_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!v.sel) begin
        if (lcd_e || ad_oe) stray = 1'b1;
      end else begin
        if (k == 1 && v.rd) chk("R8 release after rd high", ad_oe, 1'b0);
        if (k == E_FALL - 1) chk("R5 enable still high", lcd_e, 1'b1);
        if (k == E_FALL) chk("R5 enable low", lcd_e, 1'b0);
      end
    end
    if (!v.sel) chk(v.lo != 8'hFF ? "R11 low byte miss" : "R2 outside window", stray, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 lcd_e", lcd_e, 1'b0);
    chk("R1 ad_oe", ad_oe, 1'b0);
    chk("R1 lcd_db_oe", lcd_db_oe, 1'b1);
    chk("R1 rs/rw", {lcd_rs, lcd_rw}, 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R6: address change during hold is ignored until hold ends
    addr_phase(8'hA8, 8'hFF);
    wr_n = 1'b0;
    repeat (10) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    a_hi = 8'hAB;
    repeat (3) @(negedge clk);
    chk("R6 rs/rw held through hold", {lcd_rs, lcd_rw}, 2'b00);
    @(negedge clk);
    chk("R6 rs/rw follow address after hold", {lcd_rs, lcd_rw}, 2'b11);
    repeat (2) @(negedge clk);

    // R10: early release aborts the transfer
    addr_phase(8'hAA, 8'hFF);
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (lcd_e) seen = 1'b1;
    end
    chk("R10 no enable on aborted setup", seen, 1'b0);

    // R9: idle pass-through of processor data
    ad_in = 8'hC3;
    @(negedge clk);
    chk("R9 idle data follow", lcd_db_out, 8'hC3);
    chk("R9 idle drive", lcd_db_oe, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule